// File: doc/BRIEF.md
# EEPROM Page Write Buffer Controller

This block sits behind a two-wire serial slave engine and manages everything that happens between the address phase of a write and the moment the bytes land in the nonvolatile array. The slave engine hands it a byte address, then a stream of data bytes, a write-protect sample, and the bus START and STOP events. The block gathers the bytes in a page-sized holding buffer and keeps a valid flag per slot. The byte offset wraps inside the page, so a long burst overwrites its own earlier bytes. Only a STOP launches the commit.

The commit is a timed internal write cycle. For a parameterized number of system clocks (5 ms at 125 MHz by default) the block holds `busy` high, and the slave engine NACKs new commands while it is set. Early in the cycle the block walks the buffer once, in ascending slot order. It drives the external memory write port only for slots that were loaded, so untouched bytes of the page keep their old contents. The memory array itself sits outside the block, and after power-up every byte of it reads FFh.

The incoming data bytes use a valid/ready stream. A beat is taken when `in_valid` and `in_ready` are both high. `in_ready` falls during the cycle that follows an accepted STOP and stays low for the whole write cycle, so the slave engine must hold a byte and treat the low ready as NACK. The address load, write-protect strobe, START and STOP are plain single-cycle pulses, and they are ignored while `in_ready` is low.

Top module: `eeprom_page_writer`

## Requirements
- R1: A pulse on `addr_load_valid` splits `addr_load` into a page number (upper PG_W bits) and a byte offset (lower OFF_W bits). `cur_addr` equals the loaded value on the next cycle.
- R2: Each accepted data beat goes to the current offset, and then the offset increments modulo 2^OFF_W while the page stays fixed. With more than 2^OFF_W beats, the later bytes replace the earlier ones in the same slots.
- R3: Memory writes happen only during a commit. A commit writes exactly the slots loaded since the address load, each holding its last byte, all within the loaded page. Other addresses keep their contents.
- R4: An accepted STOP with at least one stored byte raises `busy` two cycles later, for exactly WR_CYCLES cycles (at least 2^OFF_W).
- R5: A `wp_strobe` pulse with `wp_level` high sets `wr_reject` from the next cycle. While it is set, data beats are accepted but not stored, and a STOP starts no write cycle.
- R6: With `wp_level` low at the strobe, writes proceed. `wr_reject` clears on STOP, START or a new address load.
- R7: A START before STOP discards the gathered bytes. A STOP with no stored byte starts no write cycle and leaves `cur_addr` at the loaded address.
- R8: A data beat accepted in the same cycle as the STOP belongs to the committed write.
- R9: After a commit, `cur_addr` points one past the last loaded byte, with the same wrap inside the page.
- R10: While `in_ready` is low (pending STOP or busy), address loads, START, STOP and write-protect strobes have no effect.
- R11: After reset `busy`, `wr_reject` and `mem_we` are 0, `in_ready` is 1 and `cur_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_load_valid | input | 1 | Load pulse for the byte address |
| addr_load | input | PG_W+OFF_W | Byte address from the address phase |
| in_valid | input | 1 | Data beat valid |
| in_ready | output | 1 | Data beat ready; low means the byte must be NACKed |
| in_data | input | 8 | Data byte |
| wp_strobe | input | 1 | Write-protect sampling instant |
| wp_level | input | 1 | Write-protect level at the strobe |
| bus_start | input | 1 | START or repeated START seen |
| bus_stop | input | 1 | STOP seen |
| busy | output | 1 | Internal write cycle in progress |
| wr_reject | output | 1 | Write protected; data bytes are NACKed |
| cur_addr | output | PG_W+OFF_W | Shared address counter |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | PG_W+OFF_W | Memory write address |
| mem_wdata | output | 8 | Memory write data |

## Verification
The last data beat and the STOP can both arrive in the same cycle. When that happens, the byte has to be stored and the commit launched from the same edge. Transactions in the sweep end this way in half the cases and with a separate STOP cycle in the other half. The bench judges each case by comparing the whole external memory image, and the address counter, against a model computed from the offset arithmetic. A second collision, an address load arriving together with a START in the middle of a write cycle, is also driven. It must leave the counter and the memory untouched.

// File: rtl/ewb_pkg.sv
package ewb_pkg;
  typedef logic [7:0] ewb_byte_t;
endpackage

// File: rtl/ewb_page_buf.sv
module ewb_page_buf
  import ewb_pkg::*;
#(
  parameter int OFF_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_idx,
  input  ewb_byte_t        wr_data,
  input  logic [OFF_W-1:0] rd_idx,
  output ewb_byte_t        rd_data,
  output logic             rd_vld
);
  localparam int DEPTH = 1 << OFF_W;

  ewb_byte_t        slot [DEPTH];
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (clr) begin
      vld <= '0;
    end else if (wr_en) begin
      vld[wr_idx]  <= 1'b1;
      slot[wr_idx] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];
  assign rd_vld  = vld[rd_idx];

  // R2: a stored byte marks its slot valid
  a_r2_slot_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> vld[$past(wr_idx)]);
  // R7: a clear empties every slot
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld == '0));
endmodule

// File: rtl/ewb_commit.sv
module ewb_commit
  import ewb_pkg::*;
#(
  parameter int OFF_W     = 6,
  parameter int PG_W      = 9,
  parameter int WR_CYCLES = 625000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  launch,
  input  logic [PG_W-1:0]       page,
  input  ewb_byte_t             buf_data,
  input  logic                  buf_vld,
  output logic [OFF_W-1:0]      scan_idx,
  output logic                  busy,
  output logic                  done,
  output logic                  mem_we,
  output logic [PG_W+OFF_W-1:0] mem_addr,
  output ewb_byte_t             mem_wdata
);
  localparam int DEPTH = 1 << OFF_W;
  localparam int CYC   = (WR_CYCLES > DEPTH) ? WR_CYCLES : DEPTH;
  localparam int CW    = $clog2(CYC + 1);

  logic [CW-1:0]   cnt;
  logic            busy_q;
  logic [PG_W-1:0] pg_q;
  logic            scan_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      busy_q <= 1'b0;
      pg_q   <= '0;
    end else if (!busy_q) begin
      if (launch) begin
        busy_q <= 1'b1;
        cnt    <= '0;
        pg_q   <= page;
      end
    end else if (cnt == CW'(CYC - 1)) begin
      busy_q <= 1'b0;
      cnt    <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign scan_idx  = cnt[OFF_W-1:0];
  assign scan_live = busy_q && (cnt < CW'(DEPTH));
  assign busy      = busy_q;
  assign done      = busy_q && (cnt == CW'(CYC - 1));
  assign mem_we    = scan_live && buf_vld;
  assign mem_addr  = {pg_q, scan_idx};
  assign mem_wdata = buf_data;

  // R4: a write cycle ends only after its full length
  a_r4_full_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt) == CW'(CYC - 1)));
  // R4: the controller never launches into a running cycle
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy_q);
  // R3: the target page holds for the whole cycle
  a_r3_page_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(pg_q));
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import ewb_pkg::*;
#(
  parameter int OFF_W     = 6,
  parameter int PG_W      = 9,
  parameter int WR_CYCLES = 625000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  addr_load_valid,
  input  logic [PG_W+OFF_W-1:0] addr_load,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [7:0]            in_data,
  input  logic                  wp_strobe,
  input  logic                  wp_level,
  input  logic                  bus_start,
  input  logic                  bus_stop,
  output logic                  busy,
  output logic                  wr_reject,
  output logic [PG_W+OFF_W-1:0] cur_addr,
  output logic                  mem_we,
  output logic [PG_W+OFF_W-1:0] mem_addr,
  output logic [7:0]            mem_wdata
);
  localparam int AW = PG_W + OFF_W;

  logic [PG_W-1:0]  pg_q;
  logic [OFF_W-1:0] off_q;
  logic             prot_q, any_q, stop_pend;
  logic             ctl_ok, load_ok, start_ok, stop_ok, store, launch_d, buf_clr, done;
  logic [OFF_W-1:0] scan_idx;
  ewb_byte_t        buf_data;
  logic             buf_vld;

  assign ctl_ok   = !busy && !stop_pend;
  assign load_ok  = addr_load_valid && ctl_ok;
  assign start_ok = bus_start && ctl_ok;
  assign stop_ok  = bus_stop && ctl_ok;
  assign store    = in_valid && ctl_ok && !prot_q && !load_ok;
  assign launch_d = stop_ok && !prot_q && (any_q || store);
  assign buf_clr  = done || load_ok || start_ok || (stop_ok && !launch_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q      <= '0;
      off_q     <= '0;
      prot_q    <= 1'b0;
      any_q     <= 1'b0;
      stop_pend <= 1'b0;
    end else begin
      stop_pend <= launch_d;
      if (load_ok) begin
        pg_q   <= addr_load[AW-1:OFF_W];
        off_q  <= addr_load[OFF_W-1:0];
        prot_q <= 1'b0;
        any_q  <= 1'b0;
      end else begin
        if (store) begin
          off_q <= off_q + 1'b1;
          any_q <= 1'b1;
        end
        if (wp_strobe && ctl_ok) prot_q <= wp_level;
        if (stop_ok || start_ok) begin
          prot_q <= 1'b0;
          any_q  <= 1'b0;
        end
      end
    end
  end

  assign in_ready  = ctl_ok;
  assign wr_reject = prot_q;
  assign cur_addr  = {pg_q, off_q};

  ewb_page_buf #(.OFF_W(OFF_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (buf_clr),
    .wr_en   (store),
    .wr_idx  (off_q),
    .wr_data (in_data),
    .rd_idx  (scan_idx),
    .rd_data (buf_data),
    .rd_vld  (buf_vld)
  );

  ewb_commit #(.OFF_W(OFF_W), .PG_W(PG_W), .WR_CYCLES(WR_CYCLES)) u_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (stop_pend),
    .page      (pg_q),
    .buf_data  (buf_data),
    .buf_vld   (buf_vld),
    .scan_idx  (scan_idx),
    .busy      (busy),
    .done      (done),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  // R2: each stored byte steps the offset by one, page unchanged
  a_r2_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> (off_q == $past(off_q) + 1'b1) && (pg_q == $past(pg_q)));
  // R5: a protected transaction never reaches a write cycle
  a_r5_reject_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stop && wr_reject && in_ready) |-> ##2 !busy);
  // R10: filling and committing never overlap
  a_r10_fill_commit_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(store && mem_we));
  // R4: busy rises two cycles after an accepted STOP that carries data
  a_r4_busy_follows_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_stop, 2));
endmodule

// File: tb/sim_eeprom_page_writer.sv
module sim_eeprom_page_writer;
  localparam int OFF_W = 6;
  localparam int PG_W  = 2;
  localparam int WRC   = 80;
  localparam int AW    = OFF_W + PG_W;
  localparam int MSZ   = 1 << AW;
  localparam int PSZ   = 1 << OFF_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_load_valid = 1'b0;
  logic [AW-1:0] addr_load = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic wp_strobe = 1'b0, wp_level = 1'b0, bus_start = 1'b0, bus_stop = 1'b0;
  logic busy, wr_reject, mem_we;
  logic [AW-1:0] cur_addr, mem_addr;
  logic [7:0] mem_wdata;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] mdl [MSZ];
  logic [7:0] expm [MSZ];

  always #4 clk = ~clk;

  eeprom_page_writer #(.OFF_W(OFF_W), .PG_W(PG_W), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_load_valid(addr_load_valid), .addr_load(addr_load),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .wp_strobe(wp_strobe), .wp_level(wp_level), .bus_start(bus_start), .bus_stop(bus_stop),
    .busy(busy), .wr_reject(wr_reject), .cur_addr(cur_addr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  always @(posedge clk) if (mem_we) mdl[mem_addr] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input int seed, input int k);
    return 8'((seed * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic cmp_mem(input string req);
    int bad = 0;
    int first = -1;
    for (int a = 0; a < MSZ; a++)
      if (mdl[a] !== expm[a]) begin bad++; if (first < 0) first = a; end
    chk(bad == 0, req, bad, 0);
    if (bad != 0) $display("  first mismatch at %0d", first);
  endtask

  // kind: 0 normal, 1 START before STOP, 2 poke address load + START while busy
  task automatic txn(input int page, input int off, input int n, input bit wp,
                     input bit stop_last, input int seed, input int kind);
    int bcnt = 0;
    int ready_bad = 0;
    int exp_addr;
    bit commits;
    @(negedge clk);
    addr_load_valid = 1'b1; addr_load = AW'(page * PSZ + off);
    @(negedge clk);
    addr_load_valid = 1'b0;
    chk(cur_addr == AW'(page * PSZ + off), "R1 load", cur_addr, page * PSZ + off);
    wp_strobe = 1'b1; wp_level = wp;
    @(negedge clk);
    wp_strobe = 1'b0; wp_level = 1'b0;
    chk(wr_reject == wp, wp ? "R5 reject set" : "R6 reject clear", wr_reject, wp);
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b1; in_data = dbyte(seed, k);
      if (k == n - 1 && stop_last && kind != 1) bus_stop = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0; bus_stop = 1'b0;
    if (kind == 1) begin
      bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
    end
    if (!stop_last || n == 0 || kind == 1) begin
      bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
    end
    commits = !wp && n > 0 && kind != 1;
    if (commits)
      for (int k = 0; k < n; k++) expm[page * PSZ + ((off + k) % PSZ)] = dbyte(seed, k);
    for (int i = 0; i < WRC + 8; i++) begin
      if (busy) begin
        bcnt++;
        if (in_ready) ready_bad++;
      end
      if (kind == 2 && i == 10) begin addr_load_valid = 1'b1; addr_load = '0; bus_start = 1'b1; end
      @(negedge clk);
      addr_load_valid = 1'b0; bus_start = 1'b0;
    end
    chk(bcnt == (commits ? WRC : 0), wp ? "R5 no cycle" : (kind == 1 ? "R7 discard" : "R4 busy length"),
        bcnt, commits ? WRC : 0);
    chk(ready_bad == 0, "R10 ready low while busy", ready_bad, 0);
    chk(wr_reject == 1'b0, "R6 reject cleared", wr_reject, 0);
    exp_addr = page * PSZ + ((wp || kind == 1) ? off : (off + n) % PSZ);
    if (kind != 1) chk(cur_addr == AW'(exp_addr), kind == 2 ? "R10 load ignored" : "R9 next address", cur_addr, exp_addr);
    cmp_mem(stop_last ? "R8 beat with STOP" : "R3 memory image");
  endtask

  initial begin
    for (int a = 0; a < MSZ; a++) begin mdl[a] = 8'hFF; expm[a] = 8'hFF; end
    repeat (3) @(negedge clk);
    chk(busy == 0 && wr_reject == 0 && mem_we == 0, "R11 reset outputs", {busy, wr_reject, mem_we}, 0);
    chk(in_ready == 1 && cur_addr == 0, "R11 reset ready/addr", {in_ready, cur_addr}, 256);
    rst_n = 1'b1;
    // sweep of offsets, lengths (R2 wrap with 64+), and STOP placement
    begin
      int offs [3] = '{0, 5, 63};
      int lens [5] = '{1, 2, 40, 64, 67};
      int seed = 1;
      for (int p = 0; p < 4; p++)
        for (int o = 0; o < 3; o++)
          for (int l = 0; l < 5; l++) begin
            txn(p, offs[o], lens[l], 1'b0, ((p + o + l) % 2) == 1, seed, 0);
            seed++;
          end
    end
    // R2 wrap explicitly: 130 bytes into page 1 from offset 10
    txn(1, 10, 130, 1'b0, 1'b0, 200, 0);
    // R5 protected write leaves memory alone
    txn(2, 3, 9, 1'b1, 1'b0, 300, 0);
    txn(3, 0, 64, 1'b1, 1'b1, 301, 0);
    // R6 write after protection allowed
    txn(2, 3, 4, 1'b0, 1'b0, 302, 0);
    // R7 repeated START discards, STOP with no data does nothing
    txn(0, 20, 6, 1'b0, 1'b0, 400, 1);
    txn(1, 33, 0, 1'b0, 1'b0, 401, 0);
    // R10 address load and START during the write cycle are ignored
    txn(3, 50, 20, 1'b0, 1'b0, 500, 2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule